// File: doc/BRIEF.md
# Table-Driven Power Rail Sequencer

This block switches a bank of sixteen power-rail enable outputs according to one of four fixed transition recipes held in a small on-chip table. A higher-level power controller picks the transition with a 2-bit selector and pulses a start input. The sequencer then works through that recipe's steps one at a time. Each step sets a single rail enable high or low, then waits a number of 1 ms ticks before the next step may run.

The four recipes cover four moves: powering up from fully off to standby, raising standby to suspend, lowering suspend back to standby, and dropping standby to fully off. A step with no wait lets the next step run on the very next clock. The block reports a busy flag while a recipe runs and a single-cycle done pulse when it finishes. Supervising power-good inputs, and deciding which recipe to launch, belong to the controller above it.

Top module: `rail_seq`

## Requirements
- R1: While rst_ni is low and after reset, rail_en_o is all zero, busy_o is 0 and done_o is 0.
- R2: A start_i sampled high while busy_o is 0 sets busy_o from the next cycle. The first step's rail write appears one cycle after that.
- R3: Steps run strictly in table order, and at most one rail enable changes per cycle. A step first writes its level. It then counts its delay of N ms as N cycles with tick_i high, after its write cycle. The next step writes on the clock edge after the edge that samples the Nth tick.
- R4: A step with zero delay is followed by the next step's write on the very next clock edge.
- R5: sel_i=0 (off to standby) sets these rail bits to 1, in this order, with these waits: bit 0 (5 V standby, 10 ms), bit 1 (1.8 V standby, 0), bit 2 (PMC I/O, 4 ms), bit 3 (PMC core, 0), bit 4 (SoC, 4 ms), bit 5 (PMC 3.3 V domain, 0).
- R6: sel_i=1 (standby to suspend) sets these rail bits to 1, in this order, with these waits: bit 6 (1.8 V S3, 0), bit 7 (1.8 V IO, 4), bit 8 (3.3 V S3, 0), bit 9 (3.3 V IO, 4), bit 10 (DDR, 4), bit 11 (LPDDR core, 4), bit 12 (LPDDR VDDQ, 4), bit 13 (media, 0), bit 14 (GPU, 0), bit 15 (CPU, 0).
- R7: sel_i=2 (suspend to standby) clears the bits in this order, with these waits: bit 15 (0), bit 14 (0), bit 13 (4), bit 12 (4), bit 11 (4), bit 10 (4), bit 9 (0), bit 8 (4), bit 7 (0), bit 6 (0).
- R8: sel_i=3 (standby to off) clears the bits in this order, with these waits: bit 5 (4), bit 4 (0), bit 3 (4), bit 2 (4), bit 1 (4), bit 0 (4).
- R9: A start_i received while busy_o is 1, including the done cycle, is ignored. The running recipe and the rail enables are unaffected.
- R10: done_o is high for exactly one cycle. That cycle follows the edge that completes the last step's wait, or the edge that writes the last step if it has no wait. busy_o falls on the next cycle.
- R11: While busy_o is 0, rail_en_o holds its value whatever sel_i and tick_i do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the recipe picked by sel_i |
| sel_i | input | 2 | Recipe selector (0..3) |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| rail_en_o | output | 16 | Rail enable bank |
| busy_o | output | 1 | Recipe in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All four recipes are run in the natural power-up and power-down order. Recipe 1 is also launched from fully off, which shows that each recipe acts only on its own rails and not on the starting state. The tick spacing changes between runs (every cycle, every 2, 3 and 7 cycles). Those spacings separate waits measured in ticks from waits measured in clocks, and they expose off-by-one errors in when a wait ends. Start pulses arrive mid-recipe and exactly in the done cycle, with a different selector, and separate a block that ignores them from one that restarts.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int unsigned RAIL_N   = 16;
  localparam int unsigned RAIL_W   = $clog2(RAIL_N);
  localparam int unsigned DLY_W    = 4;
  localparam int unsigned STEP_MAX = 10;
  localparam int unsigned IDX_W    = $clog2(STEP_MAX);

  localparam int RL_SB_5V0    = 0;
  localparam int RL_SB_1V8    = 1;
  localparam int RL_PMC_IO    = 2;
  localparam int RL_PMC_CORE  = 3;
  localparam int RL_SOC       = 4;
  localparam int RL_PMC_3V3   = 5;
  localparam int RL_S3_1V8    = 6;
  localparam int RL_IO_1V8    = 7;
  localparam int RL_S3_3V3    = 8;
  localparam int RL_IO_3V3    = 9;
  localparam int RL_DDR       = 10;
  localparam int RL_LP_CORE   = 11;
  localparam int RL_LP_Q      = 12;
  localparam int RL_MEDIA     = 13;
  localparam int RL_GPU       = 14;
  localparam int RL_CPU       = 15;

  typedef enum logic [1:0] {
    SEQ_OFF_TO_SB  = 2'd0,
    SEQ_SB_TO_SUS  = 2'd1,
    SEQ_SUS_TO_SB  = 2'd2,
    SEQ_SB_TO_OFF  = 2'd3
  } seq_sel_e;

  typedef struct packed {
    logic [RAIL_W-1:0] rail;
    logic              lvl;
    logic [DLY_W-1:0]  dly;
  } step_t;

  function automatic step_t mk(input int r, input bit l, input int d);
    step_t s;
    s.rail = RAIL_W'(r);
    s.lvl  = l;
    s.dly  = DLY_W'(d);
    return s;
  endfunction

  function automatic logic [IDX_W-1:0] seq_len(input logic [1:0] sel);
    case (sel)
      SEQ_OFF_TO_SB, SEQ_SB_TO_OFF: return IDX_W'(6);
      default:                      return IDX_W'(10);
    endcase
  endfunction

  function automatic step_t seq_step(input logic [1:0] sel, input logic [IDX_W-1:0] idx);
    step_t s;
    s = mk(0, 1'b0, 0);
    case (sel)
      SEQ_OFF_TO_SB: case (idx)
        4'd0: s = mk(RL_SB_5V0,   1'b1, 10);
        4'd1: s = mk(RL_SB_1V8,   1'b1, 0);
        4'd2: s = mk(RL_PMC_IO,   1'b1, 4);
        4'd3: s = mk(RL_PMC_CORE, 1'b1, 0);
        4'd4: s = mk(RL_SOC,      1'b1, 4);
        4'd5: s = mk(RL_PMC_3V3,  1'b1, 0);
        default: ;
      endcase
      SEQ_SB_TO_SUS: case (idx)
        4'd0: s = mk(RL_S3_1V8,  1'b1, 0);
        4'd1: s = mk(RL_IO_1V8,  1'b1, 4);
        4'd2: s = mk(RL_S3_3V3,  1'b1, 0);
        4'd3: s = mk(RL_IO_3V3,  1'b1, 4);
        4'd4: s = mk(RL_DDR,     1'b1, 4);
        4'd5: s = mk(RL_LP_CORE, 1'b1, 4);
        4'd6: s = mk(RL_LP_Q,    1'b1, 4);
        4'd7: s = mk(RL_MEDIA,   1'b1, 0);
        4'd8: s = mk(RL_GPU,     1'b1, 0);
        4'd9: s = mk(RL_CPU,     1'b1, 0);
        default: ;
      endcase
      SEQ_SUS_TO_SB: case (idx)
        4'd0: s = mk(RL_CPU,     1'b0, 0);
        4'd1: s = mk(RL_GPU,     1'b0, 0);
        4'd2: s = mk(RL_MEDIA,   1'b0, 4);
        4'd3: s = mk(RL_LP_Q,    1'b0, 4);
        4'd4: s = mk(RL_LP_CORE, 1'b0, 4);
        4'd5: s = mk(RL_DDR,     1'b0, 4);
        4'd6: s = mk(RL_IO_3V3,  1'b0, 0);
        4'd7: s = mk(RL_S3_3V3,  1'b0, 4);
        4'd8: s = mk(RL_IO_1V8,  1'b0, 0);
        4'd9: s = mk(RL_S3_1V8,  1'b0, 0);
        default: ;
      endcase
      default: case (idx)
        4'd0: s = mk(RL_PMC_3V3,  1'b0, 4);
        4'd1: s = mk(RL_SOC,      1'b0, 0);
        4'd2: s = mk(RL_PMC_CORE, 1'b0, 4);
        4'd3: s = mk(RL_PMC_IO,   1'b0, 4);
        4'd4: s = mk(RL_SB_1V8,   1'b0, 4);
        4'd5: s = mk(RL_SB_5V0,   1'b0, 4);
        default: ;
      endcase
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rail_seq_rom.sv
module rail_seq_rom
  import rail_seq_pkg::*;
(
  input  logic [1:0]       sel_i,
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o,
  output logic             last_o
);
  always_comb begin
    step_o = seq_step(sel_i, idx_i);
    last_o = (idx_i == seq_len(sel_i) - IDX_W'(1));
  end
endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (load_i)                     cnt_q <= dly_i;
    else if (tick_i && cnt_q != '0)      cnt_q <= cnt_q - DLY_W'(1);
  end

  assign expire_o = tick_i && (cnt_q == DLY_W'(1));
endmodule

// File: rtl/rail_seq_bank.sv
module rail_seq_bank #(
  parameter int unsigned RAIL_N = 16,
  localparam int unsigned RAIL_W = $clog2(RAIL_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [RAIL_W-1:0] rail_i,
  input  logic              lvl_i,
  output logic [RAIL_N-1:0] en_o
);
  for (genvar g = 0; g < RAIL_N; g++) begin : g_rail
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 en_o[g] <= 1'b0;
      else if (wr_i && rail_i == RAIL_W'(g))       en_o[g] <= lvl_i;
    end
  end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       sel_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             last_i,
  input  logic             expire_i,
  output logic [1:0]       sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wr_o,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_FIN} st_e;
  st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_o <= '0;
      idx_o <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          sel_o <= sel_i;
          idx_o <= '0;
          st_q  <= ST_RUN;
        end
        ST_RUN: begin
          if (dly_i != '0)  st_q  <= ST_WAIT;
          else if (last_i)  st_q  <= ST_FIN;
          else              idx_o <= idx_o + IDX_W'(1);
        end
        ST_WAIT: if (expire_i) begin
          if (last_i) st_q <= ST_FIN;
          else begin
            idx_o <= idx_o + IDX_W'(1);
            st_q  <= ST_RUN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_o   = (st_q == ST_RUN);
  assign load_o = (st_q == ST_RUN) && (dly_i != '0);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);
endmodule

// File: rtl/rail_seq.sv
module rail_seq
  import rail_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        sel_i,
  input  logic              tick_i,
  output logic [RAIL_N-1:0] rail_en_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [1:0]       sel_q;
  logic [IDX_W-1:0] idx_q;
  step_t            step;
  logic             last, expire, wr, load;

  rail_seq_ctrl #(.IDX_W(IDX_W), .DLY_W(DLY_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .sel_i,
    .dly_i(step.dly), .last_i(last), .expire_i(expire),
    .sel_o(sel_q), .idx_o(idx_q), .wr_o(wr), .load_o(load),
    .busy_o, .done_o
  );

  rail_seq_rom u_rom (.sel_i(sel_q), .idx_i(idx_q), .step_o(step), .last_o(last));

  rail_seq_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .dly_i(step.dly), .tick_i, .expire_o(expire)
  );

  rail_seq_bank #(.RAIL_N(RAIL_N)) u_bank (
    .clk_i, .rst_ni, .wr_i(wr), .rail_i(step.rail), .lvl_i(step.lvl), .en_o(rail_en_o)
  );
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int unsigned RAIL_N = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [RAIL_N-1:0] rail_en_o,
  input logic              busy_o,
  input logic              done_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (rail_en_o == '0 && !busy_o && !done_o)); // R1
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R2
  AST_ONE_RAIL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rail_en_o ^ $past(rail_en_o)) <= 1); // R3
  AST_BUSY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o ##1 !busy_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rail_en_o)); // R11
endmodule

bind rail_seq rail_seq_chk #(.RAIL_N(rail_seq_pkg::RAIL_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .rail_en_o(rail_en_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/rail_seq_bench.sv
module rail_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic        tick_i = 1'b0;
  logic [15:0] rail_en_o;
  logic        busy_o, done_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int tick_per = 3;
  int tick_cnt = 0;
  bit finished = 1'b0;

  int tbl [4][10];
  int tlen [4];

  int          mq[$];
  int          m_st = 0;
  int          m_cnt = 0;
  int          m_e = 0;
  logic [15:0] m_rails = '0;

  always #5 clk_i = ~clk_i;

  rail_seq u_rail_seq (.*);

  function automatic int enc(int r, int l, int d);
    return r * 256 + l * 16 + d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model: per-recipe step queue
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_rails = '0; mq.delete();
    end else begin
      case (m_st)
        0: if (start_i) begin
          for (int i = 0; i < tlen[sel_i]; i++) mq.push_back(tbl[sel_i][i]);
          m_st = 1;
        end
        1: begin
          m_e = mq.pop_front();
          m_rails[m_e / 256] = ((m_e / 16) % 16) != 0;
          if (m_e % 16 == 0) m_st = (mq.size() != 0) ? 1 : 3;
          else begin m_cnt = m_e % 16; m_st = 2; end
        end
        2: if (tick_i) begin
          m_cnt--;
          if (m_cnt == 0) m_st = (mq.size() != 0) ? 1 : 3;
        end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni === 1'b1) begin
      chk(rail_en_o === m_rails, "R3 rail order/timing", int'(rail_en_o), int'(m_rails));
      chk(busy_o === (m_st != 0), "R2 busy", int'(busy_o), int'(m_st != 0));
      chk(done_o === (m_st == 3), "R10 done", int'(done_o), int'(m_st == 3));
    end
    tick_cnt = tick_cnt + 1;
    tick_i = (tick_cnt % tick_per) == 0;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pulse_start(input logic [1:0] s);
    @(negedge clk_i);
    start_i = 1'b1; sel_i = s;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (done_o !== 1'b1) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    int t[4][10];
    t[0] = '{enc(0,1,10), enc(1,1,0), enc(2,1,4), enc(3,1,0), enc(4,1,4), enc(5,1,0), 0,0,0,0};
    t[1] = '{enc(6,1,0), enc(7,1,4), enc(8,1,0), enc(9,1,4), enc(10,1,4),
             enc(11,1,4), enc(12,1,4), enc(13,1,0), enc(14,1,0), enc(15,1,0)};
    t[2] = '{enc(15,0,0), enc(14,0,0), enc(13,0,4), enc(12,0,4), enc(11,0,4),
             enc(10,0,4), enc(9,0,0), enc(8,0,4), enc(7,0,0), enc(6,0,0)};
    t[3] = '{enc(5,0,4), enc(4,0,0), enc(3,0,4), enc(2,0,4), enc(1,0,4), enc(0,0,4), 0,0,0,0};
    tbl = t;
    tlen = '{6, 10, 10, 6};

    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1
    chk(rail_en_o == 16'h0 && !busy_o && !done_o, "R1 reset state",
        int'({busy_o, done_o, rail_en_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 off->standby, tick every 3
    tick_per = 3;
    pulse_start(2'd0);
    chk(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
    wait_done();
    chk(rail_en_o == 16'h003F, "R5 off-to-standby rails", int'(rail_en_o), 'h3F);

    // R6 standby->suspend, tick every cycle, R4 zero-delay adjacency
    tick_per = 1;
    pulse_start(2'd1);
    while (rail_en_o[6] !== 1'b1) @(negedge clk_i);
    chk(rail_en_o[7] == 1'b0, "R4 rail7 not yet", int'(rail_en_o[7]), 0);
    @(negedge clk_i);
    chk(rail_en_o[7] == 1'b1, "R4 zero-delay next cycle", int'(rail_en_o[7]), 1);
    wait_done();
    chk(rail_en_o == 16'hFFFF, "R6 standby-to-suspend rails", int'(rail_en_o), 'hFFFF);

    // R7 suspend->standby, start mid-run and in done cycle ignored (R9)
    tick_per = 2;
    pulse_start(2'd2);
    repeat (6) @(negedge clk_i);
    start_i = 1'b1; sel_i = 2'd3;
    @(negedge clk_i);
    start_i = 1'b0;
    while (done_o !== 1'b1) @(negedge clk_i);
    start_i = 1'b1; sel_i = 2'd1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b0, "R9 start in done cycle ignored", int'(busy_o), 0);
    chk(rail_en_o == 16'h003F, "R7 suspend-to-standby rails", int'(rail_en_o), 'h3F);

    // R11 idle hold under changing inputs
    sel_i = 2'd3;
    repeat (20) @(negedge clk_i);
    chk(rail_en_o == 16'h003F && !busy_o, "R11 idle hold", int'(rail_en_o), 'h3F);

    // R8 standby->off, tick every 7
    tick_per = 7;
    pulse_start(2'd3);
    wait_done();
    chk(rail_en_o == 16'h0000, "R8 standby-to-off rails", int'(rail_en_o), 0);

    // R6 from fully off: only its own rails move
    tick_per = 2;
    pulse_start(2'd1);
    wait_done();
    chk(rail_en_o == 16'hFFC0, "R6 from off", int'(rail_en_o), 'hFFC0);

    // R10 busy drops after done
    tick_per = 1;
    pulse_start(2'd2);
    while (done_o !== 1'b1) @(negedge clk_i);
    @(negedge clk_i);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R10 busy falls after done",
        int'({busy_o, done_o}), 0);
    chk(rail_en_o == 16'h0000, "R7 rails cleared", int'(rail_en_o), 0);

    repeat (4) @(negedge clk_i);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule